// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps a record of why the device last came out of reset, and lets software ask the power controller for a full system reset. It has two registers on a small register bus.

The first register holds a 4-bit request field. It is written as a multi-bit boolean. While the field holds the true code, the block drives a reset request to the power controller. When the power controller signals that the reset has completed, hardware returns the field to the false code.

The second register is the cause register. On the same completion pulse, it latches a set bit for every reset source that was active: low-power exit, the software request, and each hardware requester. Bits are sticky until software clears them with a write-one-to-clear, or until a power-on event returns the register to its reset value. A power-on reset leaves only the power-up bit set.

Top module: `rst_cause_rec`

## Requirements
- R1: After reset, the cause register reads 0x01 (only bit 0, power-up, set), the request field reads 4'b1001, and `sys_rst_req_o` is 4'b1001.
- R2: A write to address 1 clears each cause bit whose write-data bit is 1. Cause bits whose write-data bit is 0 keep their value. Cause bits never clear in any other way except through R7.
- R3: On a cycle with `rst_done_i` high, the block sets cause bits. Bit 1 is set if `lp_exit_i` is high. Bit 2 is set if the request field holds 4'b0110. Bit 3+k is set for each high `hw_rst_req_i[k]`; k=0 is the always-on system reset controller, 1 the watchdog, 2 the main power glitch, 3 alert escalation, 4 the debug-module non-debug reset. Set bits accumulate with bits already set.
- R4: A write to address 0 stores `bus_wdata_i[3:0]` in the request field, and reading address 0 returns it unchanged. `sys_rst_req_o` is 4'b0110 only while the field equals 4'b0110; every other stored value gives 4'b1001.
- R5: A cycle with `rst_done_i` high returns the request field to 4'b1001. If a software write to address 0 falls in the same cycle, the write is lost.
- R6: If a clear of a cause bit and a hardware set of that same bit fall in the same cycle, the bit ends up set.
- R7: A cycle with `por_i` high forces the cause register to 0x01 and the request field to 4'b1001. This overrides bus writes and completion pulses in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on indication, synchronous force to reset values |
| lp_exit_i | input | 1 | Low-power exit was the reset source |
| hw_rst_req_i | input | 5 | Hardware reset requesters, one bit each |
| rst_done_i | input | 1 | Reset completion pulse from the power controller |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 1 | 0 = request field, 1 = cause register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register (request field zero-extended) |
| sys_rst_req_o | output | 4 | Multi-bit boolean reset request to the power controller |
| cause_o | output | 8 | Current cause bits |

## Verification
The bench writes all sixteen request codes. This separates the single true code from fifteen near-miss codes, including the false code and values one bit away from true.

It then runs completion pulses over every combination of the five hardware requesters, the low-power-exit input and a true or false software request. Each result is compared with a cause value assembled arithmetically in the bench, which shows that each source lands on its own bit.

Directed cases cover the following:
- a clear that collides with a set;
- a request write that collides with completion;
- two completions accumulating;
- a power-on force overriding both the bus and a completion pulse.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
    localparam logic [3:0] MB4_TRUE  = 4'b0110;
    localparam logic [3:0] MB4_FALSE = 4'b1001;

    localparam int unsigned BIT_PWRUP = 0;
    localparam int unsigned BIT_LPX   = 1;
    localparam int unsigned BIT_SWREQ = 2;
    localparam int unsigned BIT_HWLSB = 3;

    typedef struct packed {
        logic [3:0] field;
    } req_state_t;
endpackage

// File: rtl/rst_cause_mb4_norm.sv
module rst_cause_mb4_norm
    import rst_cause_pkg::*;
(
    input  logic [3:0] raw_i,
    output logic       is_true_o,
    output logic [3:0] norm_o
);
    always_comb begin
        is_true_o = (raw_i == MB4_TRUE);
        norm_o    = is_true_o ? MB4_TRUE : MB4_FALSE;
    end
endmodule

// File: rtl/rst_cause_req_reg.sv
module rst_cause_req_reg
    import rst_cause_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       por_i,
    input  logic       done_i,
    input  logic       wr_i,
    input  logic [3:0] wdata_i,
    output logic [3:0] field_o
);
    req_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.field = wdata_i;
        end
        if (done_i) begin
            state_d.field = MB4_FALSE;
        end
        if (por_i) begin
            state_d.field = MB4_FALSE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{field: MB4_FALSE};
        end else begin
            state_q <= state_d;
        end
    end

    assign field_o = state_q.field;

    // R5: completion always leaves the field at the false code
    p_done_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> (field_o == MB4_FALSE));
    // R7: power-on forces the false code
    p_por_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        por_i |=> (field_o == MB4_FALSE));
    // R4: a lone write lands unchanged
    p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !done_i && !por_i) |=> (field_o == $past(wdata_i)));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int unsigned NumHw = 5,
    localparam int unsigned CauseW = BIT_HWLSB + NumHw
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              por_i,
    input  logic              done_i,
    input  logic              lpx_i,
    input  logic              sw_req_i,
    input  logic [NumHw-1:0]  hw_req_i,
    input  logic              clr_i,
    input  logic [CauseW-1:0] clr_mask_i,
    output logic [CauseW-1:0] cause_o
);
    localparam logic [CauseW-1:0] ResetVal = CauseW'(1) << BIT_PWRUP;

    logic [CauseW-1:0] cause_d, cause_q;
    logic [CauseW-1:0] set_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_LPX]   = lpx_i;
        set_vec[BIT_SWREQ] = sw_req_i;
        for (int k = 0; k < int'(NumHw); k++) begin
            set_vec[BIT_HWLSB + k] = hw_req_i[k];
        end
    end

    always_comb begin
        cause_d = cause_q;
        if (clr_i) begin
            cause_d = cause_d & ~clr_mask_i;
        end
        if (done_i) begin
            cause_d = cause_d | set_vec;
        end
        if (por_i) begin
            cause_d = ResetVal;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cause_q <= ResetVal;
        end else begin
            cause_q <= cause_d;
        end
    end

    assign cause_o = cause_q;

    // R2: without a clear or power-on, no bit falls
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!por_i && !clr_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
    // R3 / R6: hardware requesters present at completion end up recorded
    p_hw_recorded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !por_i) |=>
            ((cause_q[CauseW-1:BIT_HWLSB] & $past(hw_req_i)) == $past(hw_req_i)));
    p_lpx_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && lpx_i && !por_i) |=> cause_q[BIT_LPX]);
    // R7: power-on leaves only the power-up bit
    p_por_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        por_i |=> (cause_q == ResetVal));
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
    import rst_cause_pkg::*;
#(
    parameter int unsigned NumHw = 5,
    localparam int unsigned DataW = BIT_HWLSB + NumHw
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             por_i,
    input  logic             lp_exit_i,
    input  logic [NumHw-1:0] hw_rst_req_i,
    input  logic             rst_done_i,
    input  logic             bus_wr_i,
    input  logic             bus_addr_i,
    input  logic [DataW-1:0] bus_wdata_i,
    output logic [DataW-1:0] bus_rdata_o,
    output logic [3:0]       sys_rst_req_o,
    output logic [DataW-1:0] cause_o
);
    logic       wr_req, wr_cause;
    logic [3:0] req_field;
    logic       req_true;

    assign wr_req   = bus_wr_i && !bus_addr_i;
    assign wr_cause = bus_wr_i &&  bus_addr_i;

    rst_cause_req_reg u_req (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .por_i   (por_i),
        .done_i  (rst_done_i),
        .wr_i    (wr_req),
        .wdata_i (bus_wdata_i[3:0]),
        .field_o (req_field)
    );

    rst_cause_mb4_norm u_norm (
        .raw_i     (req_field),
        .is_true_o (req_true),
        .norm_o    (sys_rst_req_o)
    );

    rst_cause_reg #(.NumHw(NumHw)) u_cause (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .por_i      (por_i),
        .done_i     (rst_done_i),
        .lpx_i      (lp_exit_i),
        .sw_req_i   (req_true),
        .hw_req_i   (hw_rst_req_i),
        .clr_i      (wr_cause),
        .clr_mask_i (bus_wdata_i),
        .cause_o    (cause_o)
    );

    always_comb begin
        if (bus_addr_i) begin
            bus_rdata_o = cause_o;
        end else begin
            bus_rdata_o = DataW'(req_field);
        end
    end

    // R4: the output only ever carries one of the two legal codes
    p_out_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sys_rst_req_o == MB4_TRUE) || (sys_rst_req_o == MB4_FALSE));
endmodule

// File: tb/rst_cause_rec_tb.sv
module rst_cause_rec_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] T4 = 4'b0110;
    localparam logic [3:0] F4 = 4'b1001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por = 1'b0;
    logic       lpx = 1'b0;
    logic [4:0] hw = '0;
    logic       done = 1'b0;
    logic       wr = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] req_o;
    logic [7:0] cause;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_cause_rec u_dut (
        .clk_i(clk), .rst_ni(rst_n), .por_i(por), .lp_exit_i(lpx),
        .hw_rst_req_i(hw), .rst_done_i(done), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .sys_rst_req_o(req_o), .cause_o(cause)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse_done(logic l, logic [4:0] h);
        @(negedge clk);
        done = 1'b1; lpx = l; hw = h;
        @(negedge clk);
        done = 1'b0; lpx = 1'b0; hw = '0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(1'b1, v); chk("R1 cause", v, 8'h01);
        rd(1'b0, v); chk("R1 req field", v, {4'h0, F4});
        chk("R1 req out", {4'h0, req_o}, {4'h0, F4});

        // R4 sweep of every request code
        for (int c = 0; c < 16; c++) begin
            bus_write(1'b0, 8'(c));
            rd(1'b0, v); chk("R4 readback", v, 8'(c));
            chk("R4 out", {4'h0, req_o}, {4'h0, (c == 6) ? T4 : F4});
        end

        // R2 partial clear: bit0 is set, clear with mask of 0 keeps it
        bus_write(1'b0, {4'h0, F4});
        bus_write(1'b1, 8'h00);
        rd(1'b1, v); chk("R2 zero mask keeps", v, 8'h01);

        // R3 / R5 sweep: all hw patterns x lpx x sw request
        for (int h = 0; h < 32; h++) begin
            for (int l = 0; l < 2; l++) begin
                for (int s = 0; s < 2; s++) begin
                    bus_write(1'b1, 8'hFF);
                    bus_write(1'b0, {4'h0, (s == 1) ? T4 : F4});
                    pulse_done(l[0], h[4:0]);
                    rd(1'b1, v);
                    chk("R3 cause", v, 8'(h * 8 + s * 4 + l * 2));
                    rd(1'b0, v); chk("R5 cleared", v, {4'h0, F4});
                end
            end
        end

        // R2 selective clear and R3 accumulation
        bus_write(1'b1, 8'hFF);
        pulse_done(1'b0, 5'b00001);
        pulse_done(1'b1, 5'b10000);
        rd(1'b1, v); chk("R3 accumulate", v, 8'h8A);
        bus_write(1'b1, 8'h02);
        rd(1'b1, v); chk("R2 selective clear", v, 8'h88);

        // R6 clear and set collide
        @(negedge clk);
        wr = 1'b1; addr = 1'b1; wdata = 8'hFF; done = 1'b1; hw = 5'b00100;
        @(negedge clk);
        wr = 1'b0; wdata = '0; done = 1'b0; hw = '0;
        rd(1'b1, v); chk("R6 set wins", v, 8'h20);

        // R5 request write collides with completion
        @(negedge clk);
        wr = 1'b1; addr = 1'b0; wdata = {4'h0, T4}; done = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0; done = 1'b0;
        rd(1'b0, v); chk("R5 write lost", v, {4'h0, F4});
        chk("R5 out false", {4'h0, req_o}, {4'h0, F4});
        rd(1'b1, v); chk("R5 no sw cause", v, 8'h20);

        // R7 power-on forces over bus write and completion
        bus_write(1'b0, {4'h0, T4});
        @(negedge clk);
        por = 1'b1; done = 1'b1; hw = 5'h1F; lpx = 1'b1;
        wr = 1'b1; addr = 1'b0; wdata = {4'h0, T4};
        @(negedge clk);
        por = 1'b0; done = 1'b0; hw = '0; lpx = 1'b0; wr = 1'b0; wdata = '0;
        rd(1'b1, v); chk("R7 cause", v, 8'h01);
        rd(1'b0, v); chk("R7 req", v, {4'h0, F4});
        chk("R7 out", {4'h0, req_o}, {4'h0, F4});

        summary();
    end
endmodule